// File: doc/BRIEF.md
# Heartbeat Load, Rate and Event Watchdog

This block supervises a system that advances in virtual cycles marked by a heartbeat pulse. It has three monitors. The first adds up the operations issued between heartbeats and flags any virtual cycle whose total goes above a programmed safe limit. The second counts heartbeats over a fixed window of clock cycles and flags any window whose count falls short of a programmed floor. The third is a bank of event channels. A trigger arms each channel, the channel then counts heartbeats, and it expects its event within a tolerance band around a programmed delay.

When a channel's band closes and no event has arrived, the channel can raise an alarm, emit a stand-in event, or do both. A separate marker flags the stand-in event, so downstream logic can tell it apart from a real one. Every alarm is sticky. A write-one-to-clear strobe removes alarms. The delays, the tolerance, the limits and the substitution modes are all configuration inputs.

Top module: `hb_watchdog`

## Requirements
- R1: The operations counted by `op_cnt` are summed over every clock from the cycle after one `hb` pulse up to and including the next `hb` clock, saturating at the counter width. If that sum is strictly greater than `load_limit`, `load_alarm` is high from the cycle after the `hb` clock. A sum equal to the limit raises no alarm.
- R2: Heartbeats are counted over consecutive windows of max(`rate_win`,1) clocks. If a window ends with a count below `rate_floor`, `rate_alarm` is set in the following cycle. A count equal to the floor sets nothing.
- R3: A pulse on `trig[i]` arms channel i and sets its heartbeat count to zero. A trigger on a channel that is already armed restarts the count from zero.
- R4: An armed channel accepts an event on `evt_in[i]` only while its count lies between `delay[i]-tol` and `delay[i]+tol`. Acceptance disarms the channel with no alarm. An earlier event is ignored for supervision, and the channel stays armed.
- R5: If an armed channel receives `hb` while its count equals `delay[i]+tol`, the channel expires. In `sub_mode` 0 (alarm only), 2 or 3, `evt_alarm[i]` is set in the following cycle.
- R6: The `sub_mode` field of channel i is `sub_mode[2i+1:2i]`. In modes 1 (substitute only), 2 and 3, an expiry drives `evt_out[i]` and `evt_subst[i]` high for exactly one cycle, in the cycle after the expiry. Mode 1 raises no alarm.
- R7: Every real event on `evt_in[i]` appears on `evt_out[i]` one cycle later with `evt_subst[i]` low, whether the channel is armed or not.
- R8: Alarms stay set until cleared. A cycle with `clr_valid` high clears each alarm whose `clr_mask` bit is 1. The mask bits are: bit 0 for load, bit 1 for rate, bit 2+i for channel i. A set in the same cycle wins over the clear.
- R9: After reset, all alarms, `evt_out` and `evt_subst` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb | input | 1 | Heartbeat pulse closing a virtual cycle |
| op_cnt | input | OPW | Operations issued in this clock |
| load_limit | input | CW | Safe operation count per virtual cycle |
| rate_win | input | WINW | Rate window length in clocks |
| rate_floor | input | WINW | Minimum heartbeats per window |
| trig | input | NCH | Per-channel arming pulses |
| evt_in | input | NCH | Per-channel real events |
| delay | input | NCH*DW | Per-channel expected delay in heartbeats, channel i at bits [i*DW +: DW] |
| tol | input | TW | Acceptance tolerance in heartbeats, shared by all channels |
| sub_mode | input | 2*NCH | Per-channel substitution mode |
| clr_valid | input | 1 | Clear strobe |
| clr_mask | input | NCH+2 | Alarms to clear |
| load_alarm | output | 1 | Sticky overload alarm |
| rate_alarm | output | 1 | Sticky low-rate alarm |
| evt_alarm | output | NCH | Sticky missed-event alarms |
| evt_out | output | NCH | Forwarded or substituted events |
| evt_subst | output | NCH | Marks a substituted event |

## Verification
The bench uses the default parameters: eight channels, a 4-bit operation input, a 12-bit load counter, 16-bit rate fields, 8-bit delays and a 4-bit tolerance. It programs short delays, a tolerance of 0 or 1 and a 10-clock rate window. With these values the edges of both acceptance bands, a re-armed channel, every substitution mode and the exact rate floor can all be reached within a few hundred clocks. A heartbeat period equal to the window length puts exactly one heartbeat in every window, whatever the window phase. That makes the equal-to-floor case exact.

// File: rtl/hbw_pkg.sv
package hbw_pkg;

   typedef enum logic [1:0] {
      SUB_OFF    = 2'd0,
      SUB_ONLY   = 2'd1,
      SUB_ALARM  = 2'd2,
      SUB_ALARM3 = 2'd3
   } sub_mode_e;

   localparam int ALM_LOAD = 0;
   localparam int ALM_RATE = 1;
   localparam int ALM_CH0  = 2;

   function automatic logic mode_alarms(input logic [1:0] m);
      return m != SUB_ONLY;
   endfunction

   function automatic logic mode_substitutes(input logic [1:0] m);
      return m != SUB_OFF;
   endfunction

endpackage

// File: rtl/hbw_load.sv
module hbw_load #(
   parameter int OPW = 4,
   parameter int CW  = 12
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           hb,
   input  logic [OPW-1:0] op_cnt,
   input  logic [CW-1:0]  limit,
   output logic           over
);
   logic [CW-1:0] acc;
   logic [CW:0]   sum_w;
   logic [CW-1:0] sum;

   always_comb begin
      sum_w = {1'b0, acc} + {{(CW+1-OPW){1'b0}}, op_cnt};
      sum   = sum_w[CW] ? {CW{1'b1}} : sum_w[CW-1:0];
      over  = hb && (sum > limit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  acc <= '0;
      else if (hb) acc <= '0;
      else         acc <= sum;
   end
endmodule

// File: rtl/hbw_rate.sv
module hbw_rate #(
   parameter int WINW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hb,
   input  logic [WINW-1:0] win_len,
   input  logic [WINW-1:0] floor_cnt,
   output logic            low,
   output logic            win_end
);
   logic [WINW-1:0] clk_cnt;
   logic [WINW-1:0] hb_cnt;
   logic [WINW:0]   next_clk;
   logic [WINW:0]   hb_w;
   logic [WINW-1:0] hb_tot;

   always_comb begin
      next_clk = {1'b0, clk_cnt} + 1'b1;
      win_end  = next_clk >= {1'b0, win_len};
      hb_w     = {1'b0, hb_cnt} + {{WINW{1'b0}}, hb};
      hb_tot   = hb_w[WINW] ? {WINW{1'b1}} : hb_w[WINW-1:0];
      low      = win_end && (hb_tot < floor_cnt);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_cnt <= '0;
         hb_cnt  <= '0;
      end else if (win_end) begin
         clk_cnt <= '0;
         hb_cnt  <= '0;
      end else begin
         clk_cnt <= next_clk[WINW-1:0];
         hb_cnt  <= hb_tot;
      end
   end
endmodule

// File: rtl/hbw_chan.sv
module hbw_chan
   import hbw_pkg::*;
#(
   parameter int DW = 8,
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hb,
   input  logic          trig,
   input  logic          evt,
   input  logic [DW-1:0] dly,
   input  logic [TW-1:0] tol,
   input  logic [1:0]    mode,
   output logic          miss,
   output logic          evt_o,
   output logic          sub_o
);
   localparam int HW = DW + 1;

   logic          armed;
   logic [HW-1:0] cnt;
   logic [HW-1:0] hi;
   logic [HW:0]   lo_sum;
   logic          in_win, accept, expire;

   always_comb begin
      hi     = {1'b0, dly} + {{(HW-TW){1'b0}}, tol};
      lo_sum = {1'b0, cnt} + {{(HW+1-TW){1'b0}}, tol};
      in_win = armed && (lo_sum >= {2'b00, dly});
      accept = in_win && evt && !trig;
      expire = armed && hb && (cnt == hi) && !trig && !accept;
      miss   = expire && mode_alarms(mode);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         cnt   <= '0;
         evt_o <= 1'b0;
         sub_o <= 1'b0;
      end else begin
         if (trig) begin
            armed <= 1'b1;
            cnt   <= '0;
         end else if (accept || expire) begin
            armed <= 1'b0;
         end else if (armed && hb) begin
            cnt   <= cnt + 1'b1;
         end
         evt_o <= evt || (expire && mode_substitutes(mode));
         sub_o <= expire && mode_substitutes(mode);
      end
   end
endmodule

// File: rtl/hb_watchdog.sv
module hb_watchdog
   import hbw_pkg::*;
#(
   parameter int NCH  = 8,
   parameter int OPW  = 4,
   parameter int CW   = 12,
   parameter int WINW = 16,
   parameter int DW   = 8,
   parameter int TW   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hb,
   input  logic [OPW-1:0]    op_cnt,
   input  logic [CW-1:0]     load_limit,
   input  logic [WINW-1:0]   rate_win,
   input  logic [WINW-1:0]   rate_floor,
   input  logic [NCH-1:0]    trig,
   input  logic [NCH-1:0]    evt_in,
   input  logic [NCH*DW-1:0] delay,
   input  logic [TW-1:0]     tol,
   input  logic [2*NCH-1:0]  sub_mode,
   input  logic              clr_valid,
   input  logic [NCH+1:0]    clr_mask,
   output logic              load_alarm,
   output logic              rate_alarm,
   output logic [NCH-1:0]    evt_alarm,
   output logic [NCH-1:0]    evt_out,
   output logic [NCH-1:0]    evt_subst
);
   localparam int NA = NCH + 2;

   initial begin : p_param_check
      if (NCH < 1)   $error("hb_watchdog: NCH must be at least 1");
      if (OPW > CW)  $error("hb_watchdog: OPW must not exceed CW");
      if (TW > DW)   $error("hb_watchdog: TW must not exceed DW");
      if (WINW < 2)  $error("hb_watchdog: WINW must be at least 2");
   end

   logic [NA-1:0]  alm;
   logic [NA-1:0]  alm_set;
   logic [NA-1:0]  alm_clr;
   logic           load_over;
   logic           rate_low;
   logic           rate_win_end;
   logic [NCH-1:0] ch_miss;

   hbw_load #(.OPW(OPW), .CW(CW)) i_load (
      .clk(clk), .rst_n(rst_n), .hb(hb), .op_cnt(op_cnt),
      .limit(load_limit), .over(load_over)
   );

   hbw_rate #(.WINW(WINW)) i_rate (
      .clk(clk), .rst_n(rst_n), .hb(hb), .win_len(rate_win),
      .floor_cnt(rate_floor), .low(rate_low), .win_end(rate_win_end)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      hbw_chan #(.DW(DW), .TW(TW)) i_chan (
         .clk(clk), .rst_n(rst_n), .hb(hb), .trig(trig[g]), .evt(evt_in[g]),
         .dly(delay[g*DW +: DW]), .tol(tol), .mode(sub_mode[2*g +: 2]),
         .miss(ch_miss[g]), .evt_o(evt_out[g]), .sub_o(evt_subst[g])
      );
   end

   always_comb begin
      alm_set = {ch_miss, rate_low, load_over};
      alm_clr = clr_valid ? clr_mask : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) alm <= '0;
      else        alm <= (alm & ~alm_clr) | alm_set;
   end

   assign load_alarm = alm[ALM_LOAD];
   assign rate_alarm = alm[ALM_RATE];
   assign evt_alarm  = alm[NA-1:ALM_CH0];
endmodule

// File: rtl/hbw_chk.sv
module hbw_chk #(
   parameter int NCH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hb,
   input logic             win_end,
   input logic [NCH-1:0]   evt_in,
   input logic [2*NCH-1:0] sub_mode,
   input logic             clr_valid,
   input logic [NCH+1:0]   clr_mask,
   input logic             load_alarm,
   input logic             rate_alarm,
   input logic [NCH-1:0]   evt_alarm,
   input logic [NCH-1:0]   evt_out,
   input logic [NCH-1:0]   evt_subst
);
   logic [NCH+1:0] all_alm;
   assign all_alm = {evt_alarm, rate_alarm, load_alarm};

   AST_LOAD_AFTER_HB: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(load_alarm) |-> $past(hb)); // R1

   AST_RATE_AT_WINDOW_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rate_alarm) |-> $past(win_end)); // R2

   for (genvar a = 0; a < NCH + 2; a++) begin : g_alm
      AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (all_alm[a] && !(clr_valid && clr_mask[a])) |=> all_alm[a]); // R8
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      AST_SUBST_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
         evt_subst[c] |-> evt_out[c]); // R6

      AST_SUBST_ONLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(evt_alarm[c]) |-> ($past(sub_mode[2*c +: 2]) != 2'd1)); // R6

      AST_REAL_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(evt_in[c]) && $past(rst_n)) |-> (evt_out[c] && !evt_subst[c])); // R7
   end
endmodule

bind hb_watchdog hbw_chk #(.NCH(NCH)) i_hbw_chk (
   .clk(clk), .rst_n(rst_n), .hb(hb), .win_end(rate_win_end),
   .evt_in(evt_in), .sub_mode(sub_mode), .clr_valid(clr_valid),
   .clr_mask(clr_mask), .load_alarm(load_alarm), .rate_alarm(rate_alarm),
   .evt_alarm(evt_alarm), .evt_out(evt_out), .evt_subst(evt_subst)
);

// File: tb/test_hb_watchdog.sv
module test_hb_watchdog;
   localparam int NCH = 8, OPW = 4, CW = 12, WINW = 16, DW = 8, TW = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              hb = 1'b0;
   logic [OPW-1:0]    op_cnt = '0;
   logic [CW-1:0]     load_limit = '1;
   logic [WINW-1:0]   rate_win = 16'd10;
   logic [WINW-1:0]   rate_floor = '0;
   logic [NCH-1:0]    trig = '0;
   logic [NCH-1:0]    evt_in = '0;
   logic [NCH*DW-1:0] delay = '0;
   logic [TW-1:0]     tol = 4'd1;
   logic [2*NCH-1:0]  sub_mode = '0;
   logic              clr_valid = 1'b0;
   logic [NCH+1:0]    clr_mask = '0;
   logic              load_alarm, rate_alarm;
   logic [NCH-1:0]    evt_alarm, evt_out, evt_subst;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   hb_watchdog #(.NCH(NCH), .OPW(OPW), .CW(CW), .WINW(WINW), .DW(DW), .TW(TW)) i_hb_watchdog (
      .clk(clk), .rst_n(rst_n), .hb(hb), .op_cnt(op_cnt), .load_limit(load_limit),
      .rate_win(rate_win), .rate_floor(rate_floor), .trig(trig), .evt_in(evt_in),
      .delay(delay), .tol(tol), .sub_mode(sub_mode), .clr_valid(clr_valid),
      .clr_mask(clr_mask), .load_alarm(load_alarm), .rate_alarm(rate_alarm),
      .evt_alarm(evt_alarm), .evt_out(evt_out), .evt_subst(evt_subst)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic hb_pulse();
      hb = 1'b1; @(negedge clk); hb = 1'b0;
   endtask

   task automatic hbs(input int n);
      for (int k = 0; k < n; k++) hb_pulse();
   endtask

   task automatic trig_pulse(input int ch);
      trig[ch] = 1'b1; @(negedge clk); trig[ch] = 1'b0;
   endtask

   task automatic evt_pulse(input int ch);
      evt_in[ch] = 1'b1; @(negedge clk); evt_in[ch] = 1'b0;
   endtask

   task automatic clear_all();
      clr_valid = 1'b1; clr_mask = '1; @(negedge clk); clr_valid = 1'b0; clr_mask = '0;
   endtask

   task automatic t_reset();
      chk("R9 load_alarm", load_alarm, 0);
      chk("R9 rate_alarm", rate_alarm, 0);
      chk("R9 evt_alarm", evt_alarm, 0);
      chk("R9 evt_out", evt_out, 0);
      chk("R9 evt_subst", evt_subst, 0);
   endtask

   task automatic t_load();
      load_limit = 12'd5;
      op_cnt = 4'd2; step(2);
      op_cnt = 4'd1; hb = 1'b1; step(1); hb = 1'b0; op_cnt = '0;
      chk("R1 sum equal to limit", load_alarm, 0);
      op_cnt = 4'd3; step(1);
      hb = 1'b1; step(1); hb = 1'b0; op_cnt = '0;
      chk("R1 sum above limit", load_alarm, 1);
      step(3);
      chk("R8 load alarm sticky", load_alarm, 1);
      clr_valid = 1'b1; clr_mask = 10'h001; step(1); clr_valid = 1'b0;
      chk("R8 load alarm cleared", load_alarm, 0);
      op_cnt = 4'd6; hb = 1'b1; clr_valid = 1'b1; clr_mask = 10'h001; step(1);
      hb = 1'b0; clr_valid = 1'b0; op_cnt = '0;
      chk("R8 set wins over clear", load_alarm, 1);
      clear_all();
      load_limit = '1;
   endtask

   task automatic t_rate();
      rate_win = 16'd10; rate_floor = 16'd1;
      for (int k = 0; k < 8; k++) begin
         hb_pulse();
         if (k == 2) begin
            clr_valid = 1'b1; clr_mask = 10'h002; @(negedge clk); clr_valid = 1'b0;
            step(8);
         end else step(9);
      end
      chk("R2 count equal to floor", rate_alarm, 0);
      rate_floor = 16'd2;
      for (int k = 0; k < 3; k++) begin hb_pulse(); step(9); end
      chk("R2 count below floor", rate_alarm, 1);
      rate_floor = '0;
      clear_all();
      chk("R8 rate alarm cleared", rate_alarm, 0);
   endtask

   task automatic t_window();
      delay[0*DW +: DW] = 8'd4; tol = 4'd1; sub_mode[1:0] = 2'd0;
      trig_pulse(0); hbs(4); evt_pulse(0);
      chk("R7 real event forwarded", evt_out[0], 1);
      chk("R7 real event not marked", evt_subst[0], 0);
      hbs(3);
      chk("R4 on-time event accepted", evt_alarm, 0);
      trig_pulse(0); hbs(3); evt_pulse(0); hbs(3);
      chk("R4 lower band edge accepted", evt_alarm, 0);
      trig_pulse(0); hbs(5); evt_pulse(0); hbs(3);
      chk("R4 upper band edge accepted", evt_alarm, 0);
      trig_pulse(0); hbs(2); evt_pulse(0); hbs(3);
      chk("R4 early event ignored, not yet expired", evt_alarm, 0);
      hb_pulse();
      chk("R5 expiry alarm", evt_alarm, 8'h01);
      chk("R5 mode 0 no substitute", evt_out[0], 0);
      clear_all();
   endtask

   task automatic t_subst();
      delay[1*DW +: DW] = 8'd2; delay[2*DW +: DW] = 8'd2; tol = 4'd0;
      sub_mode[3:2] = 2'd1; sub_mode[5:4] = 2'd2;
      trig = 8'h06; @(negedge clk); trig = '0;
      hbs(2);
      chk("R5 no expiry before deadline", evt_out, 0);
      hb_pulse();
      chk("R6 substitute events", evt_out, 8'h06);
      chk("R6 substitute marker", evt_subst, 8'h06);
      chk("R6 mode 1 quiet, mode 2 alarms", evt_alarm, 8'h04);
      step(1);
      chk("R6 substitute one cycle", evt_out, 0);
      clear_all();
   endtask

   task automatic t_rearm();
      delay[3*DW +: DW] = 8'd4; tol = 4'd0; sub_mode[7:6] = 2'd0;
      trig_pulse(3); hbs(3); trig_pulse(3); hbs(4); evt_pulse(3); hbs(2);
      chk("R3 retrigger restarts count", evt_alarm, 0);
      evt_pulse(5);
      chk("R7 unarmed event forwarded", evt_out, 8'h20);
      step(1);
      chk("R7 unarmed event no alarm", evt_alarm, 0);
   endtask

   initial begin : p_watchdog
      #2_000_000;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : p_main
      step(3);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_load();
      t_rate();
      t_window();
      t_subst();
      t_rearm();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule